// File: doc/BRIEF.md
# Ternary CAM with Priority Match

This block is a small ternary content-addressable memory. Each entry stores a key word, a per-bit don't-care mask, a short format tag and a valid bit. An empty location is simply one whose valid bit is clear. A single command input selects one operation per cycle:
- write at an explicit index
- write into the lowest free index
- invalidate one index
- invalidate everything
- search
- step to the next match

A search compares the presented key against all entries in the same cycle. Per-search byte enables can remove whole byte columns from the comparison. The block registers a hit flag and the binary index of the lowest-numbered hit, which has the highest priority. The full set of hits from that search is kept. A next-match command retires the current winner and reports the next one in one cycle, without searching again.

A continuously updated output names the lowest-numbered free location. A side RAM holds one associated word per entry. It is written with the entry and read out using the registered hit index, so the associated word of a hit appears one cycle after the hit is reported.

Top module: `tcam_core`

## Requirements
- R1: After a synchronous active-high reset: hit_flag is 0, hit_idx is 0, free_flag is 1, free_idx is 0 and assoc_out is 0.
- R2: The cmd codes are: 0 idle, 1 write-at, 2 write-free, 3 invalidate, 4 invalidate-all, 5 search, 6 next-match, and 7 idle. On an idle cycle every output holds its value. A search registers its result on the edge that samples it.
- R3: A stored mask bit of 1 makes that bit position match any search key bit.
- R4: When col_en[b] is 0, search key bits 8b+7..8b are left out of the comparison for every entry.
- R5: An entry can match only when its stored format tag equals the search's fmt_in.
- R6: When several entries hit, hit_idx is the binary index of the lowest-numbered one. When nothing hits, hit_flag is 0 and hit_idx is 0.
- R7: A write sets the entry's valid bit. Invalidate clears the valid bit of the entry at addr, and invalidate-all clears every valid bit. An entry whose valid bit is clear never matches.
- R8: Write-at stores at addr and overwrites whatever is there. Write-free stores at the current free_idx. Write-free is ignored when free_flag is 0.
- R9: Next-match removes the current winner from the kept hit set and reports the next lowest hit in the same cycle. The search key and fmt_in are ignored during next-match. When no hit remains, hit_flag becomes 0.
- R10: free_flag and free_idx give the lowest-numbered invalid entry. They reflect a change of validity on the same edge that makes the change. free_flag is 0 when every entry is valid.
- R11: assoc_out holds the associated word of the entry named by hit_idx, one cycle after hit_idx is updated.
- R12: Write-at, write-free (even when ignored), invalidate and invalidate-all clear the kept hit set and force hit_flag and hit_idx to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code (see R2) |
| addr | input | IW (5) | Entry index for write-at and invalidate |
| key_in | input | DATA_W (32) | Key to store, or search key |
| mask_in | input | DATA_W (32) | Don't-care mask to store (1 = ignore bit) |
| fmt_in | input | FMT_W (2) | Format tag to store or to search for |
| assoc_in | input | ASSOC_W (16) | Associated word to store with the entry |
| col_en | input | DATA_W/8 (4) | Per-byte search enables (1 = byte compared) |
| hit_flag | output | 1 | At least one entry is in the kept hit set |
| hit_idx | output | IW (5) | Index of the winning entry |
| free_flag | output | 1 | At least one entry is invalid |
| free_idx | output | IW (5) | Lowest-numbered invalid entry |
| assoc_out | output | ASSOC_W (16) | Associated word of the entry at hit_idx |

## Verification
A corrupt valid bit shows up at free_idx on the very next edge. It also causes a missing or extra hit on the next search of a key that entry would match. A stale entry left in the kept hit set after a write shows up as hit_flag staying high after a write command. A winner that is not cleared properly on next-match shows up as hit_idx failing to rise, one edge after the command. A wrong associated-RAM address shows up one cycle later, when assoc_out does not match the word written with the reported entry.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE      = 3'd0,
    CMD_WR_AT     = 3'd1,
    CMD_WR_FREE   = 3'd2,
    CMD_INVAL     = 3'd3,
    CMD_INVAL_ALL = 3'd4,
    CMD_SEARCH    = 3'd5,
    CMD_NEXT      = 3'd6,
    CMD_SPARE     = 3'd7
  } tcam_cmd_e;
endpackage

// File: rtl/tcam_prio_enc.sv
// Lowest set bit wins; idx is zero when nothing is set.
module tcam_prio_enc #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/tcam_match_array.sv
module tcam_match_array #(
  parameter int ENTRIES = 32,
  parameter int DATA_W  = 32,
  parameter int FMT_W   = 2,
  parameter int IW      = $clog2(ENTRIES),
  parameter int BYTES   = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [DATA_W-1:0]  wr_key,
  input  logic [DATA_W-1:0]  wr_mask,
  input  logic [FMT_W-1:0]   wr_fmt,
  input  logic               clr_en,
  input  logic [IW-1:0]      clr_idx,
  input  logic               clr_all,
  input  logic [DATA_W-1:0]  s_key,
  input  logic [FMT_W-1:0]   s_fmt,
  input  logic [BYTES-1:0]   s_col,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [ENTRIES-1:0] valid_nx
);
  logic [DATA_W-1:0]  key_q  [ENTRIES];
  logic [DATA_W-1:0]  mask_q [ENTRIES];
  logic [FMT_W-1:0]   fmt_q  [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [DATA_W-1:0]  col_bits;

  for (genvar b = 0; b < BYTES; b++) begin : g_col
    assign col_bits[b*8 +: 8] = {8{s_col[b]}};
  end

  always_comb begin
    valid_nx = valid_q;
    if (clr_all) begin
      valid_nx = '0;
    end else begin
      if (wr_en)  valid_nx[wr_idx]  = 1'b1;
      if (clr_en) valid_nx[clr_idx] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else     valid_q <= valid_nx;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      key_q[wr_idx]  <= wr_key;
      mask_q[wr_idx] <= wr_mask;
      fmt_q[wr_idx]  <= wr_fmt;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [DATA_W-1:0] diff;
    assign diff       = (key_q[e] ^ s_key) & ~mask_q[e] & col_bits;
    assign hit_vec[e] = valid_q[e] && (fmt_q[e] == s_fmt) && (diff == '0);
  end
endmodule

// File: rtl/tcam_assoc_ram.sv
// Simple dual-port RAM with registered read, block-RAM shaped.
module tcam_assoc_ram #(
  parameter int DEPTH = 32,
  parameter int W     = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/tcam_core.sv
module tcam_core
  import tcam_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int DATA_W  = 32,
  parameter int FMT_W   = 2,
  parameter int ASSOC_W = 16,
  localparam int IW     = $clog2(ENTRIES),
  localparam int BYTES  = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         cmd,
  input  logic [IW-1:0]      addr,
  input  logic [DATA_W-1:0]  key_in,
  input  logic [DATA_W-1:0]  mask_in,
  input  logic [FMT_W-1:0]   fmt_in,
  input  logic [ASSOC_W-1:0] assoc_in,
  input  logic [BYTES-1:0]   col_en,
  output logic               hit_flag,
  output logic [IW-1:0]      hit_idx,
  output logic               free_flag,
  output logic [IW-1:0]      free_idx,
  output logic [ASSOC_W-1:0] assoc_out
);
  tcam_cmd_e          op;
  logic               wr_en, clr_en, clr_all, drop_hits;
  logic [IW-1:0]      wr_idx;
  logic [ENTRIES-1:0] cmp_vec, valid_nx, hit_q, retired, sel_vec;
  logic               sel_any, free_any;
  logic [IW-1:0]      sel_idx, free_c;

  assign op        = tcam_cmd_e'(cmd);
  assign wr_en     = (op == CMD_WR_AT) || (op == CMD_WR_FREE && free_flag);
  assign wr_idx    = (op == CMD_WR_AT) ? addr : free_idx;
  assign clr_en    = (op == CMD_INVAL);
  assign clr_all   = (op == CMD_INVAL_ALL);
  assign drop_hits = (op == CMD_WR_AT) || (op == CMD_WR_FREE) || clr_en || clr_all;

  tcam_match_array #(
    .ENTRIES(ENTRIES), .DATA_W(DATA_W), .FMT_W(FMT_W), .IW(IW), .BYTES(BYTES)
  ) u_array (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_key(key_in), .wr_mask(mask_in), .wr_fmt(fmt_in),
    .clr_en(clr_en), .clr_idx(addr), .clr_all(clr_all),
    .s_key(key_in), .s_fmt(fmt_in), .s_col(col_en),
    .hit_vec(cmp_vec), .valid_nx(valid_nx)
  );

  // Retire the current winner from the kept set for next-match.
  assign retired = hit_q & ~(ENTRIES'(1) << hit_idx);
  assign sel_vec = (op == CMD_SEARCH) ? cmp_vec : retired;

  tcam_prio_enc #(.N(ENTRIES), .IW(IW)) u_hit_enc (
    .vec(sel_vec), .any(sel_any), .idx(sel_idx)
  );

  tcam_prio_enc #(.N(ENTRIES), .IW(IW)) u_free_enc (
    .vec(~valid_nx), .any(free_any), .idx(free_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q     <= '0;
      hit_flag  <= 1'b0;
      hit_idx   <= '0;
      free_flag <= 1'b1;
      free_idx  <= '0;
    end else begin
      free_flag <= free_any;
      free_idx  <= free_c;
      if (op == CMD_SEARCH || op == CMD_NEXT) begin
        hit_q    <= sel_vec;
        hit_flag <= sel_any;
        hit_idx  <= sel_idx;
      end else if (drop_hits) begin
        hit_q    <= '0;
        hit_flag <= 1'b0;
        hit_idx  <= '0;
      end
    end
  end

  tcam_assoc_ram #(.DEPTH(ENTRIES), .W(ASSOC_W), .AW(IW)) u_assoc (
    .clk(clk), .rst(rst),
    .we(wr_en), .waddr(wr_idx), .wdata(assoc_in),
    .raddr(hit_idx), .rdata(assoc_out)
  );
endmodule

// File: rtl/tcam_core_chk.sv
module tcam_core_chk
  import tcam_pkg::*;
#(
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    cmd,
  input logic          hit_flag,
  input logic [IW-1:0] hit_idx,
  input logic          free_flag,
  input logic [IW-1:0] free_idx
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!hit_flag && hit_idx == '0 && free_flag && free_idx == '0));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_IDLE) |=> ($stable(hit_flag) && $stable(hit_idx) &&
                           $stable(free_flag) && $stable(free_idx)));

  p_clear_all_frees_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_INVAL_ALL) |=> (free_flag && free_idx == '0));

  p_full_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_WR_FREE && !free_flag) |=> !free_flag);

  p_next_rises_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_NEXT && hit_flag) |=> (!hit_flag || hit_idx > $past(hit_idx)));

  p_next_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_NEXT && !hit_flag) |=> !hit_flag);

  p_free_moves_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_WR_FREE && free_flag) |=> (!free_flag || free_idx > $past(free_idx)));

  p_write_drops_r12: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_WR_AT || cmd == CMD_WR_FREE || cmd == CMD_INVAL || cmd == CMD_INVAL_ALL)
    |=> (!hit_flag && hit_idx == '0));
endmodule

bind tcam_core tcam_core_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst(rst), .cmd(cmd),
  .hit_flag(hit_flag), .hit_idx(hit_idx),
  .free_flag(free_flag), .free_idx(free_idx)
);

// File: tb/sim_tcam_core.sv
`timescale 1ns/1ps
module sim_tcam_core;
  localparam int ENTRIES = 32;
  localparam int DATA_W  = 32;
  localparam int FMT_W   = 2;
  localparam int ASSOC_W = 16;
  localparam int IW      = $clog2(ENTRIES);
  localparam int BYTES   = DATA_W / 8;

  typedef struct packed {
    logic [2:0]  cmd;
    logic [4:0]  addr;
    logic [31:0] key;
    logic [31:0] mask;
    logic [1:0]  fmt;
    logic [15:0] asc;
    logic [3:0]  col;
    logic        mf;
    logic [4:0]  midx;
    logic        ff;
    logic [4:0]  fidx;
    logic [7:0]  req;
  } vec_t;

  function automatic vec_t mk(input logic [2:0] c, input logic [4:0] a,
                              input logic [31:0] k, input logic [31:0] m,
                              input logic [1:0] f, input logic [15:0] s,
                              input logic [3:0] ce, input logic emf,
                              input logic [4:0] emi, input logic eff,
                              input logic [4:0] efi, input logic [7:0] r);
    vec_t v;
    v.cmd = c; v.addr = a; v.key = k; v.mask = m; v.fmt = f; v.asc = s;
    v.col = ce; v.mf = emf; v.midx = emi; v.ff = eff; v.fidx = efi; v.req = r;
    return v;
  endfunction

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    mk(3'd2, 5'd0, 32'hA000_0001, 32'h0,         2'd0, 16'h1111, 4'hF, 1'b0, 5'd0, 1'b1, 5'd1,  8'd8),  // R8 write-free at 0
    mk(3'd1, 5'd5, 32'h1234_5678, 32'h0000_00FF, 2'd0, 16'h5555, 4'hF, 1'b0, 5'd0, 1'b1, 5'd1,  8'd8),  // R8 write-at 5
    mk(3'd1, 5'd3, 32'h1234_0000, 32'h0,         2'd1, 16'h3333, 4'hF, 1'b0, 5'd0, 1'b1, 5'd1,  8'd5),  // R5 entry with tag 1
    mk(3'd2, 5'd0, 32'h1234_5600, 32'h0,         2'd0, 16'h2222, 4'hF, 1'b0, 5'd0, 1'b1, 5'd2,  8'd10), // R10 free moves to 2
    mk(3'd5, 5'd0, 32'h1234_56AB, 32'h0,         2'd0, 16'h0,    4'hF, 1'b1, 5'd5, 1'b1, 5'd2,  8'd3),  // R3 masked low byte
    mk(3'd5, 5'd0, 32'h1234_56AB, 32'h0,         2'd0, 16'h0,    4'hE, 1'b1, 5'd1, 1'b1, 5'd2,  8'd4),  // R4 R6 byte 0 off
    mk(3'd6, 5'd0, 32'hFFFF_FFFF, 32'h0,         2'd3, 16'h0,    4'h0, 1'b1, 5'd5, 1'b1, 5'd2,  8'd9),  // R9 next hit
    mk(3'd6, 5'd0, 32'h0,         32'h0,         2'd0, 16'h0,    4'hF, 1'b0, 5'd0, 1'b1, 5'd2,  8'd9),  // R9 exhausted
    mk(3'd5, 5'd0, 32'h1234_0000, 32'h0,         2'd0, 16'h0,    4'hF, 1'b0, 5'd0, 1'b1, 5'd2,  8'd5),  // R5 wrong tag
    mk(3'd5, 5'd0, 32'h1234_0000, 32'h0,         2'd1, 16'h0,    4'hF, 1'b1, 5'd3, 1'b1, 5'd2,  8'd5),  // R5 right tag
    mk(3'd3, 5'd3, 32'h0,         32'h0,         2'd0, 16'h0,    4'hF, 1'b0, 5'd0, 1'b1, 5'd2,  8'd12), // R12 invalidate drops hit
    mk(3'd5, 5'd0, 32'h1234_0000, 32'h0,         2'd1, 16'h0,    4'hF, 1'b0, 5'd0, 1'b1, 5'd2,  8'd7),  // R7 invalid never hits
    mk(3'd1, 5'd2, 32'h0,         32'hFFFF_FFFF, 2'd2, 16'h7777, 4'hF, 1'b0, 5'd0, 1'b1, 5'd3,  8'd10), // R10 free to 3
    mk(3'd5, 5'd0, 32'hDEAD_BEEF, 32'h0,         2'd2, 16'h0,    4'hF, 1'b1, 5'd2, 1'b1, 5'd3,  8'd3),  // R3 full wildcard
    mk(3'd4, 5'd0, 32'h0,         32'h0,         2'd0, 16'h0,    4'hF, 1'b0, 5'd0, 1'b1, 5'd0,  8'd7),  // R7 invalidate-all
    mk(3'd5, 5'd0, 32'hDEAD_BEEF, 32'h0,         2'd2, 16'h0,    4'hF, 1'b0, 5'd0, 1'b1, 5'd0,  8'd7)   // R7 nothing after clear
  };

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [2:0]         cmd = 3'd0;
  logic [IW-1:0]      addr = '0;
  logic [DATA_W-1:0]  key_in = '0;
  logic [DATA_W-1:0]  mask_in = '0;
  logic [FMT_W-1:0]   fmt_in = '0;
  logic [ASSOC_W-1:0] assoc_in = '0;
  logic [BYTES-1:0]   col_en = '1;
  logic               hit_flag, free_flag;
  logic [IW-1:0]      hit_idx, free_idx;
  logic [ASSOC_W-1:0] assoc_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tcam_core #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .FMT_W(FMT_W), .ASSOC_W(ASSOC_W)) u0 (
    .clk(clk), .rst(rst), .cmd(cmd), .addr(addr), .key_in(key_in), .mask_in(mask_in),
    .fmt_in(fmt_in), .assoc_in(assoc_in), .col_en(col_en),
    .hit_flag(hit_flag), .hit_idx(hit_idx), .free_flag(free_flag), .free_idx(free_idx),
    .assoc_out(assoc_out)
  );

  // Called at a falling edge; returns at the next falling edge with cmd back to idle.
  task automatic op(input logic [2:0] c, input logic [IW-1:0] a, input logic [31:0] k,
                    input logic [31:0] m, input logic [1:0] f, input logic [15:0] s,
                    input logic [3:0] ce);
    cmd = c; addr = a; key_in = k; mask_in = m; fmt_in = f; assoc_in = s; col_en = ce;
    @(negedge clk);
    cmd = 3'd0;
  endtask

  task automatic chk(input string tag, input logic emf, input logic [IW-1:0] emi,
                     input logic eff, input logic [IW-1:0] efi);
    n_chk++;
    if (hit_flag !== emf || hit_idx !== emi || free_flag !== eff || free_idx !== efi) begin
      n_fail++;
      $display("FAIL %s: actual hit=%0b idx=%0d free=%0b fidx=%0d expected hit=%0b idx=%0d free=%0b fidx=%0d",
               tag, hit_flag, hit_idx, free_flag, free_idx, emf, emi, eff, efi);
    end
  endtask

  task automatic chk_assoc(input string tag, input logic [ASSOC_W-1:0] exp);
    n_chk++;
    if (assoc_out !== exp) begin
      n_fail++;
      $display("FAIL %s: actual assoc=%h expected assoc=%h", tag, assoc_out, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset outputs", 1'b0, '0, 1'b1, '0);
    chk_assoc("R1 reset assoc", '0);

    for (int i = 0; i < NV; i++) begin
      op(TBL[i].cmd, TBL[i].addr, TBL[i].key, TBL[i].mask, TBL[i].fmt, TBL[i].asc, TBL[i].col);
      chk($sformatf("R%0d vector %0d", TBL[i].req, i), TBL[i].mf, TBL[i].midx, TBL[i].ff, TBL[i].fidx);
    end

    // R11: associated word one cycle after the hit
    op(3'd1, 5'd4, 32'hCAFE_0004, 32'h0, 2'd0, 16'hABCD, 4'hF);
    op(3'd5, 5'd0, 32'hCAFE_0004, 32'h0, 2'd0, 16'h0, 4'hF);
    chk("R11 search hit", 1'b1, 5'd4, 1'b1, 5'd0);
    @(negedge clk);
    chk_assoc("R11 assoc after hit", 16'hABCD);

    // R2: idle keeps outputs
    repeat (3) @(negedge clk);
    chk("R2 idle hold", 1'b1, 5'd4, 1'b1, 5'd0);

    // R8: write-at overwrites an existing entry
    op(3'd1, 5'd4, 32'h5555_0004, 32'h0, 2'd0, 16'h4444, 4'hF);
    op(3'd5, 5'd0, 32'hCAFE_0004, 32'h0, 2'd0, 16'h0, 4'hF);
    chk("R8 old key gone", 1'b0, '0, 1'b1, 5'd0);
    op(3'd5, 5'd0, 32'h5555_0004, 32'h0, 2'd0, 16'h0, 4'hF);
    chk("R8 new key found", 1'b1, 5'd4, 1'b1, 5'd0);

    // R10: fill the array
    op(3'd4, 5'd0, 32'h0, 32'h0, 2'd0, 16'h0, 4'hF);
    for (int i = 0; i < ENTRIES; i++) begin
      op(3'd2, 5'd0, 32'h0100_0000 + i, 32'h0, 2'd0, 16'h8000 + 16'(i), 4'hF);
    end
    chk("R10 array full", 1'b0, '0, 1'b0, '0);

    // R8: write-free into a full array is ignored
    op(3'd2, 5'd0, 32'h9999_9999, 32'h0, 2'd0, 16'h9999, 4'hF);
    chk("R8 full write-free", 1'b0, '0, 1'b0, '0);
    op(3'd5, 5'd0, 32'h9999_9999, 32'h0, 2'd0, 16'h0, 4'hF);
    chk("R8 ignored key absent", 1'b0, '0, 1'b0, '0);

    // R11 and R9 on the filled array
    op(3'd5, 5'd0, 32'h0100_0007, 32'h0, 2'd0, 16'h0, 4'hF);
    chk("R11 hit entry 7", 1'b1, 5'd7, 1'b0, '0);
    @(negedge clk);
    chk_assoc("R11 assoc entry 7", 16'h8007);
    op(3'd6, 5'd0, 32'h0100_0007, 32'h0, 2'd0, 16'h0, 4'hF);
    chk("R9 single hit retired", 1'b0, '0, 1'b0, '0);

    // R4: only byte 3 compared, all entries share 0x01 there; R6 lowest wins
    op(3'd5, 5'd0, 32'h01FF_FFFF, 32'h0, 2'd0, 16'h0, 4'h8);
    chk("R6 lowest of many", 1'b1, 5'd0, 1'b0, '0);
    op(3'd6, 5'd0, 32'h0, 32'h0, 2'd0, 16'h0, 4'h0);
    chk("R9 second of many", 1'b1, 5'd1, 1'b0, '0);

    // R10 and R12: invalidate a middle entry
    op(3'd3, 5'd9, 32'h0, 32'h0, 2'd0, 16'h0, 4'hF);
    chk("R10 R12 invalidate 9", 1'b0, '0, 1'b1, 5'd9);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule